// File: doc/BRIEF.md
# Page Permission Fault Checker

This block decides whether an access that already has a translation may go ahead. Its inputs are the permission bits of the leaf page table entry, the kind of access, the effective privilege, and the two supervisor override bits (permit-user-access and make-executable-readable). Two copies of those override bits are presented, one from the host supervisor and one from the virtual supervisor. A virtualization flag, a flag that names the guest (second) translation stage, and a hypervisor execute-as-load flag complete the inputs. For every valid request it returns a fault flag and the matching exception cause code. The cause is either an ordinary page-fault cause or a guest page-fault cause.

The decision logic is purely combinational. Its outputs are registered once, so a verdict appears on the cycle after the request. The block takes no part in address translation or in physical memory protection. A separate error output flags a guest-stage request made while virtualization is off, so that a surrounding environment can catch an inconsistent caller.

Top module: `pgperm_checker`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, out_valid, fault, cause and stage_err are all zero.
- R2: The outputs show the verdict for a request one clock after in_valid is high, with out_valid high. One clock after in_valid is low, out_valid, fault, stage_err and cause are zero.
- R3: With exec_as_load high, the R/W/X stage of the check looks only at pte_x and faults when pte_x is 0. The privilege stage (R6, R7) still applies.
- R4: A load (acc_kind 2'b00) of an entry with pte_r at 0 faults, unless the effective make-executable-readable bit and pte_x are both 1.
- R5: A store (acc_kind 2'b01) faults when pte_w is 0. A fetch (acc_kind 2'b10 or 2'b11) faults when pte_x is 0.
- R6: A user-privilege access (priv_user = 1) to an entry with pte_u at 0 faults.
- R7: A supervisor access (priv_user = 0) to an entry with pte_u at 1 faults when the access is a fetch or the effective permit-user-access bit is 0. A supervisor access to an entry with pte_u at 0 does not fault on account of privilege.
- R8: When virt_on is 1 and stage_guest is 0, the effective permit-user-access bit is vs_sum and the effective make-executable-readable bit is hs_mxr OR vs_mxr. In every other case they are hs_sum and hs_mxr.
- R9: On a fault, cause is 12 for a fetch, 13 for a load and 15 for a store when stage_guest is 0. It is 20, 21 and 23 respectively when stage_guest is 1. When there is no fault, cause is 0.
- R10: stage_err is 1 one clock after a valid request with stage_guest at 1 and virt_on at 0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| pte_r | input | 1 | Entry readable bit |
| pte_w | input | 1 | Entry writable bit |
| pte_x | input | 1 | Entry executable bit |
| pte_u | input | 1 | Entry user-accessible bit |
| acc_kind | input | 2 | 00 load, 01 store, 1x fetch |
| priv_user | input | 1 | 1 = user privilege, 0 = supervisor |
| hs_sum | input | 1 | Host permit-user-access bit |
| hs_mxr | input | 1 | Host make-executable-readable bit |
| vs_sum | input | 1 | Virtual-supervisor permit-user-access bit |
| vs_mxr | input | 1 | Virtual-supervisor make-executable-readable bit |
| virt_on | input | 1 | Access runs virtualized |
| stage_guest | input | 1 | Check belongs to the guest (second) stage |
| exec_as_load | input | 1 | Hypervisor load that needs execute permission |
| out_valid | output | 1 | Verdict valid |
| fault | output | 1 | Access denied |
| cause | output | CAUSE_W | Exception cause code, 0 when no fault |
| stage_err | output | 1 | Guest stage requested while not virtualized |

## Verification
If the effective override bits are chosen from the wrong status copy, the error shows only when virt_on and the host and virtual bits disagree. It then appears as a flipped fault on the very next cycle, so vectors are built with the two copies set opposite. A bad ordering of the permission and privilege stages cannot alter the fault flag. An encoding slip in the cause selector shows in the cause field one cycle after a faulting request. Because of that, every fault vector checks the exact code, not just the flag. A stale output register shows as nonzero fault or cause on the cycle after an idle input.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD      = 2'b00,
    ACC_STORE     = 2'b01,
    ACC_FETCH     = 2'b10,
    ACC_FETCH_ALT = 2'b11
  } acc_e;

  localparam int unsigned CAUSE_W_DEF = 6;
endpackage

// File: rtl/pgperm_rwx.sv
module pgperm_rwx
  import pgperm_pkg::*;
(
  input  logic pte_r,
  input  logic pte_w,
  input  logic pte_x,
  input  acc_e acc,
  input  logic exec_as_load,
  input  logic eff_mxr,
  output logic rwx_ok
);
  logic load_ok;

  always_comb begin
    load_ok = pte_r || (eff_mxr && pte_x);
    if (exec_as_load) begin
      rwx_ok = pte_x;
    end else begin
      unique case (acc)
        ACC_LOAD:  rwx_ok = load_ok;
        ACC_STORE: rwx_ok = pte_w;
        default:   rwx_ok = pte_x;
      endcase
    end
  end

  always_comb begin
    if (exec_as_load && !pte_x) begin
      assert (!rwx_ok) else $error("AST_XL_NEEDS_X");  // R3
    end
  end
endmodule

// File: rtl/pgperm_priv.sv
module pgperm_priv (
  input  logic pte_u,
  input  logic priv_user,
  input  logic is_fetch,
  input  logic eff_sum,
  output logic priv_ok
);
  always_comb begin
    if (priv_user) begin
      priv_ok = pte_u;
    end else if (pte_u) begin
      priv_ok = eff_sum && !is_fetch;
    end else begin
      priv_ok = 1'b1;
    end
  end

  always_comb begin
    if (!priv_user && !pte_u) begin
      assert (priv_ok) else $error("AST_SUP_OWN_PAGE_OK");  // R7
    end
  end
endmodule

// File: rtl/pgperm_cause.sv
module pgperm_cause
  import pgperm_pkg::*;
#(
  parameter int unsigned CAUSE_W      = CAUSE_W_DEF,
  parameter int unsigned FETCH_CODE   = 12,
  parameter int unsigned LOAD_CODE    = 13,
  parameter int unsigned STORE_CODE   = 15,
  parameter int unsigned GUEST_OFFSET = 8
) (
  input  acc_e               acc,
  input  logic               guest,
  output logic [CAUSE_W-1:0] code
);
  localparam logic [CAUSE_W-1:0] C_FETCH = CAUSE_W'(FETCH_CODE);
  localparam logic [CAUSE_W-1:0] C_LOAD  = CAUSE_W'(LOAD_CODE);
  localparam logic [CAUSE_W-1:0] C_STORE = CAUSE_W'(STORE_CODE);
  localparam logic [CAUSE_W-1:0] C_GOFF  = CAUSE_W'(GUEST_OFFSET);

  logic [CAUSE_W-1:0] base;

  always_comb begin
    unique case (acc)
      ACC_LOAD:  base = C_LOAD;
      ACC_STORE: base = C_STORE;
      default:   base = C_FETCH;
    endcase
    code = guest ? (base + C_GOFF) : base;
  end
endmodule

// File: rtl/pgperm_checker.sv
module pgperm_checker
  import pgperm_pkg::*;
#(
  parameter int unsigned CAUSE_W = CAUSE_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               pte_r,
  input  logic               pte_w,
  input  logic               pte_x,
  input  logic               pte_u,
  input  logic [1:0]         acc_kind,
  input  logic               priv_user,
  input  logic               hs_sum,
  input  logic               hs_mxr,
  input  logic               vs_sum,
  input  logic               vs_mxr,
  input  logic               virt_on,
  input  logic               stage_guest,
  input  logic               exec_as_load,
  output logic               out_valid,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause,
  output logic               stage_err
);
  acc_e               acc;
  logic               first_virt;
  logic               eff_sum;
  logic               eff_mxr;
  logic               rwx_ok;
  logic               priv_ok;
  logic               fault_c;
  logic [CAUSE_W-1:0] code_c;

  always_comb begin
    acc        = acc_e'(acc_kind);
    first_virt = virt_on && !stage_guest;
    eff_sum    = first_virt ? vs_sum : hs_sum;
    eff_mxr    = hs_mxr || (first_virt && vs_mxr);
  end

  pgperm_rwx u_rwx (
    .pte_r        (pte_r),
    .pte_w        (pte_w),
    .pte_x        (pte_x),
    .acc          (acc),
    .exec_as_load (exec_as_load),
    .eff_mxr      (eff_mxr),
    .rwx_ok       (rwx_ok)
  );

  pgperm_priv u_priv (
    .pte_u     (pte_u),
    .priv_user (priv_user),
    .is_fetch  (acc_kind[1]),
    .eff_sum   (eff_sum),
    .priv_ok   (priv_ok)
  );

  pgperm_cause #(.CAUSE_W(CAUSE_W)) u_cause (
    .acc   (acc),
    .guest (stage_guest),
    .code  (code_c)
  );

  // privilege stage is consulted only once the R/W/X stage has passed
  assign fault_c = !rwx_ok || !priv_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      fault     <= 1'b0;
      cause     <= '0;
      stage_err <= 1'b0;
    end else begin
      out_valid <= in_valid;
      fault     <= in_valid && fault_c;
      cause     <= (in_valid && fault_c) ? code_c : '0;
      stage_err <= in_valid && stage_guest && !virt_on;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!fault && cause == '0 && !stage_err));  // R2
  AST_CAUSE_PAIRS_FAULT: assert property (@(posedge clk) disable iff (rst)
    fault == (cause != '0));  // R9
  AST_NO_PERM_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !pte_r && !pte_w && !pte_x) |=> fault);  // R4
  AST_GUEST_CAUSE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && stage_guest) |=> (!fault || cause >= CAUSE_W'(20)));  // R9
  AST_STAGE_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && stage_guest && !virt_on) |=> stage_err);  // R10
endmodule

// File: tb/pgperm_checker_tb.sv
module pgperm_checker_tb;
  localparam int CW = 6;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic pte_r = 1'b0, pte_w = 1'b0, pte_x = 1'b0, pte_u = 1'b0;
  logic [1:0] acc_kind = 2'b00;
  logic priv_user = 1'b0;
  logic hs_sum = 1'b0, hs_mxr = 1'b0, vs_sum = 1'b0, vs_mxr = 1'b0;
  logic virt_on = 1'b0, stage_guest = 1'b0, exec_as_load = 1'b0;
  logic out_valid, fault, stage_err;
  logic [CW-1:0] cause;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pgperm_checker #(.CAUSE_W(CW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x), .pte_u(pte_u),
    .acc_kind(acc_kind), .priv_user(priv_user),
    .hs_sum(hs_sum), .hs_mxr(hs_mxr), .vs_sum(vs_sum), .vs_mxr(vs_mxr),
    .virt_on(virt_on), .stage_guest(stage_guest), .exec_as_load(exec_as_load),
    .out_valid(out_valid), .fault(fault), .cause(cause), .stage_err(stage_err)
  );

  // rwxu | acc | user | hs_sum hs_mxr vs_sum vs_mxr | virt guest xl | fault | cause
  localparam logic [20:0] VEC [NV] = '{
    {4'b1001, 2'd0, 1'b1, 4'b0000, 3'b000, 1'b0, 6'd0 },  // R4 R6 readable user page
    {4'b0011, 2'd0, 1'b1, 4'b0000, 3'b000, 1'b1, 6'd13},  // R4 no R, no mxr
    {4'b0011, 2'd0, 1'b1, 4'b0100, 3'b000, 1'b0, 6'd0 },  // R4 mxr lets exec page be read
    {4'b1001, 2'd1, 1'b1, 4'b0000, 3'b000, 1'b1, 6'd15},  // R5 store no W
    {4'b1101, 2'd1, 1'b1, 4'b0000, 3'b000, 1'b0, 6'd0 },  // R5 store ok
    {4'b1001, 2'd2, 1'b1, 4'b0000, 3'b000, 1'b1, 6'd12},  // R5 fetch no X
    {4'b1001, 2'd3, 1'b1, 4'b0000, 3'b000, 1'b1, 6'd12},  // R5 fetch alt code
    {4'b0010, 2'd2, 1'b1, 4'b0000, 3'b000, 1'b1, 6'd12},  // R6 user fetch of non-user page
    {4'b1000, 2'd0, 1'b1, 4'b0000, 3'b000, 1'b1, 6'd13},  // R6 user load of non-user page
    {4'b1001, 2'd0, 1'b0, 4'b0000, 3'b000, 1'b1, 6'd13},  // R7 sup on user page, sum 0
    {4'b1001, 2'd0, 1'b0, 4'b1000, 3'b000, 1'b0, 6'd0 },  // R7 sup on user page, sum 1
    {4'b0011, 2'd2, 1'b0, 4'b1000, 3'b000, 1'b1, 6'd12},  // R7 sup fetch of user page
    {4'b1000, 2'd0, 1'b0, 4'b0000, 3'b000, 1'b0, 6'd0 },  // R7 sup own page
    {4'b1001, 2'd0, 1'b0, 4'b1000, 3'b100, 1'b1, 6'd13},  // R8 virt uses vs_sum=0
    {4'b1001, 2'd0, 1'b0, 4'b0010, 3'b100, 1'b0, 6'd0 },  // R8 virt uses vs_sum=1
    {4'b0010, 2'd0, 1'b0, 4'b0001, 3'b100, 1'b0, 6'd0 },  // R8 vs_mxr merged
    {4'b0010, 2'd0, 1'b0, 4'b0001, 3'b110, 1'b1, 6'd21},  // R8 R9 guest stage ignores vs_mxr
    {4'b1001, 2'd1, 1'b1, 4'b0000, 3'b110, 1'b1, 6'd23},  // R9 guest store
    {4'b1001, 2'd2, 1'b1, 4'b0000, 3'b110, 1'b1, 6'd20},  // R9 guest fetch
    {4'b0011, 2'd0, 1'b1, 4'b0000, 3'b001, 1'b0, 6'd0 },  // R3 exec-as-load, X set, R clear
    {4'b1001, 2'd0, 1'b1, 4'b0100, 3'b001, 1'b1, 6'd13},  // R3 exec-as-load, X clear
    {4'b0010, 2'd0, 1'b0, 4'b0000, 3'b001, 1'b0, 6'd0 }   // R3 exec-as-load, sup own page
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [20:0] v);
    {pte_r, pte_w, pte_x, pte_u} = v[20:17];
    acc_kind  = v[16:15];
    priv_user = v[14];
    {hs_sum, hs_mxr, vs_sum, vs_mxr} = v[13:10];
    {virt_on, stage_guest, exec_as_load} = v[9:7];
    in_valid  = 1'b1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {31'd0, out_valid}, 0);
    check("R1 fault in reset", {31'd0, fault}, 0);
    check("R1 cause in reset", {26'd0, cause}, 0);
    check("R1 stage_err in reset", {31'd0, stage_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", {31'd0, out_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      check("R2 out_valid", {31'd0, out_valid}, 1);
      check($sformatf("vector %0d fault", i), {31'd0, fault}, {31'd0, VEC[i][6]});
      check($sformatf("vector %0d cause", i), {26'd0, cause}, {26'd0, VEC[i][5:0]});
      check("R10 stage_err low", {31'd0, stage_err}, 0);
    end

    // R2: idle cycle after a faulting request clears everything
    apply({4'b0000, 2'd1, 1'b1, 4'b0000, 3'b000, 1'b1, 6'd15});
    @(negedge clk);
    check("R2 faulting request", {31'd0, fault}, 1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 idle out_valid", {31'd0, out_valid}, 0);
    check("R2 idle fault", {31'd0, fault}, 0);
    check("R2 idle cause", {26'd0, cause}, 0);

    // R10: guest stage while not virtualized
    apply({4'b1001, 2'd1, 1'b1, 4'b0000, 3'b010, 1'b1, 6'd23});
    @(negedge clk);
    check("R10 stage_err set", {31'd0, stage_err}, 1);
    check("R9 guest store cause", {26'd0, cause}, 23);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 stage_err clears", {31'd0, stage_err}, 0);

    // R1: reset mid-stream clears registered verdict
    apply({4'b0000, 2'd0, 1'b1, 4'b0000, 3'b000, 1'b1, 6'd13});
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset overrides request", {31'd0, fault}, 0);
    check("R1 reset clears out_valid", {31'd0, out_valid}, 0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule